// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early Warning

This block is a watchdog peripheral on a simple 32-bit register bus. Software programs a 32-bit timeout value and a 32-bit early-warning threshold, each written as a low and a high 16-bit half. It then enables a down-counter that steps once for each pulse of a slow tick enable, which stands in for a 32.768 kHz time base, so 32768 steps make one second. When the count passes the threshold, a raw warning flag is set. That flag drives a maskable interrupt. When the count reaches zero, a raw expiry flag is set and a one-cycle reset request is issued.

Every register write except one to the lock register is discarded unless the block has been unlocked first. Unlocking takes a 16-bit key. Programming a load half raises a busy flag. The new values reach the counter two ticks later, and the busy flag then drops. Reloading the timeout in this way is also how software kicks the watchdog.

Top module: `wdog_keylock`

## Requirements
- R1: After reset the block is locked (lock register bit 0 reads 0). Control, mask, count and raw status all read 0, and irq and rst_req are low.
- R2: Writing 0xE551 to the lock register (offset 0x20) unlocks the block, and the lock register then reads 1. Writing any other value locks it again.
- R3: While the block is locked, a write to any register other than the lock register changes nothing. Reads are always served.
- R4: The timeout value is written as a low half at 0x00 and a high half at 0x04. The threshold is written as a low half at 0x2C and a high half at 0x30. Each half uses data bits 15:0. The count reads back as bits 15:0 at 0x18 and bits 31:16 at 0x1C.
- R5: A write to any load half sets busy (raw status bit 4, offset 0x10). On the second tick after the last such write, busy clears, the count takes the timeout value, and the threshold takes effect.
- R6: While control bit 1 is set and busy is low, the count drops by one on each tick and holds at zero. With bit 1 clear the count holds.
- R7: When the count steps onto the threshold, raw status bit 0 is set and stays set. irq equals that flag ANDed with control bit 0 and with the inverse of mask bit 0 (offset 0x14, 1 = masked).
- R8: When the count steps from 1 to 0, raw status bit 3 is set. If control bit 3 is set, rst_req is also high for exactly one cycle.
- R9: Writing the clear register (offset 0x0C) with bit 0 set clears raw bit 0. Writing it with bit 3 set clears raw bit 3.
- R10: Reloading a timeout half while the counter runs holds the count during busy, then restarts it from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow time-base enable, one cycle per step |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
Read data is combinational, so a register written at one clock edge is read back during the next low phase of the clock. The busy flag, the raw flags and the count change on the clock edge that captures a write or a tick, and the bench samples them at the next falling edge. The load takes effect at the edge of the second tick after the write. The bench therefore checks that busy is still high after one tick, and checks busy low and the new count after the second tick. rst_req is registered and lasts one cycle, so it is sampled once, at the falling edge right after each tick edge. The bench counts pulses over a whole run.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam int OFF_LOAD_LO = 'h00;
   localparam int OFF_LOAD_HI = 'h04;
   localparam int OFF_CTRL    = 'h08;
   localparam int OFF_CLEAR   = 'h0C;
   localparam int OFF_RAW     = 'h10;
   localparam int OFF_MASK    = 'h14;
   localparam int OFF_CNT_LO  = 'h18;
   localparam int OFF_CNT_HI  = 'h1C;
   localparam int OFF_LOCK    = 'h20;
   localparam int OFF_PRE_LO  = 'h2C;
   localparam int OFF_PRE_HI  = 'h30;
   // control bit positions
   localparam int C_INT = 0;
   localparam int C_CNT = 1;
   localparam int C_VER = 2;
   localparam int C_RST = 3;
   // raw status bit positions
   localparam int S_INT  = 0;
   localparam int S_RST  = 3;
   localparam int S_BUSY = 4;
   localparam int NUM_HALVES = 4;
   // half index -> offset: timeout lo, timeout hi, threshold lo, threshold hi
   function automatic int half_off(input int idx);
      case (idx)
         0: return OFF_LOAD_LO;
         1: return OFF_LOAD_HI;
         2: return OFF_PRE_LO;
         default: return OFF_PRE_HI;
      endcase
   endfunction
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
   import wdk_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int ADDR_W = 6,
   parameter logic [15:0] KEY = 16'hE551,
   localparam int DATA_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              unlocked,
   output logic [3:0]        ctrl,
   output logic              mask,
   output logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] pre_val,
   output logic              load_wr,
   output logic              clr_int,
   output logic              clr_rst
);
   logic              wr_ok;
   logic [HALF_W-1:0] half_q [NUM_HALVES];
   logic [NUM_HALVES-1:0] half_hit;

   assign wr_ok = we && unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
      end else if (we && addr == ADDR_W'(OFF_LOCK)) begin
         unlocked <= (wdata[15:0] == KEY);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         mask <= 1'b0;
      end else if (wr_ok) begin
         if (addr == ADDR_W'(OFF_CTRL)) ctrl <= wdata[3:0];
         if (addr == ADDR_W'(OFF_MASK)) mask <= wdata[0];
      end
   end

   for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
      assign half_hit[g] = wr_ok && addr == ADDR_W'(half_off(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) half_q[g] <= '0;
         else if (half_hit[g]) half_q[g] <= wdata[HALF_W-1:0];
      end
   end

   assign load_val = {half_q[1], half_q[0]};
   assign pre_val  = {half_q[3], half_q[2]};
   assign load_wr  = |half_hit;
   assign clr_int  = wr_ok && addr == ADDR_W'(OFF_CLEAR) && wdata[S_INT];
   assign clr_rst  = wr_ok && addr == ADDR_W'(OFF_CLEAR) && wdata[S_RST];
endmodule

// File: rtl/wdk_core.sv
module wdk_core #(
   parameter int DATA_W = 32,
   parameter int LOAD_TICKS = 2,
   localparam int TK_W = (LOAD_TICKS < 2) ? 1 : $clog2(LOAD_TICKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load_wr,
   input  logic [DATA_W-1:0] load_val,
   input  logic [DATA_W-1:0] pre_val,
   input  logic              cnt_en,
   input  logic              rst_en,
   input  logic              clr_int,
   input  logic              clr_rst,
   output logic [DATA_W-1:0] count,
   output logic              busy,
   output logic              raw_int,
   output logic              raw_rst,
   output logic              rst_req
);
   logic [TK_W-1:0]   tk;
   logic [DATA_W-1:0] thresh;
   logic [DATA_W-1:0] next_cnt;
   logic              step;
   logic              load_done;

   assign next_cnt  = count - DATA_W'(1);
   assign step      = cnt_en && !busy && tick && count != '0;
   assign load_done = busy && tick && !load_wr && tk == TK_W'(LOAD_TICKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         tk     <= '0;
         count  <= '0;
         thresh <= '0;
      end else if (load_wr) begin
         busy <= 1'b1;
         tk   <= '0;
      end else if (load_done) begin
         busy   <= 1'b0;
         count  <= load_val;
         thresh <= pre_val;
      end else if (busy && tick) begin
         tk <= tk + TK_W'(1);
      end else if (step) begin
         count <= next_cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_int <= 1'b0;
         raw_rst <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (clr_int) raw_int <= 1'b0;
         if (clr_rst) raw_rst <= 1'b0;
         if (step && !load_wr && next_cnt == thresh) raw_int <= 1'b1;
         if (step && !load_wr && next_cnt == '0) begin
            raw_rst <= 1'b1;
            rst_req <= rst_en;
         end
      end
   end
endmodule

// File: rtl/wdog_keylock.sv
module wdog_keylock
   import wdk_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int ADDR_W = 6,
   parameter int LOAD_TICKS = 2,
   parameter logic [15:0] KEY = 16'hE551,
   localparam int DATA_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              rst_req
);
   initial begin
      if (HALF_W < 16) $error("HALF_W must be at least 16");
      if (ADDR_W < 6) $error("ADDR_W must reach the highest offset");
      if (LOAD_TICKS < 1) $error("LOAD_TICKS must be at least 1");
   end

   logic              unlocked, mask, load_wr, clr_int, clr_rst;
   logic [3:0]        ctrl;
   logic [DATA_W-1:0] load_val, pre_val, count;
   logic              busy, raw_int, raw_rst;
   logic [DATA_W-1:0] raw_word;

   wdk_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .unlocked(unlocked), .ctrl(ctrl), .mask(mask), .load_val(load_val),
      .pre_val(pre_val), .load_wr(load_wr), .clr_int(clr_int), .clr_rst(clr_rst)
   );

   wdk_core #(.DATA_W(DATA_W), .LOAD_TICKS(LOAD_TICKS)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(load_wr),
      .load_val(load_val), .pre_val(pre_val), .cnt_en(ctrl[C_CNT]),
      .rst_en(ctrl[C_RST]), .clr_int(clr_int), .clr_rst(clr_rst),
      .count(count), .busy(busy), .raw_int(raw_int), .raw_rst(raw_rst),
      .rst_req(rst_req)
   );

   assign irq = raw_int && ctrl[C_INT] && !mask;

   always_comb begin
      raw_word         = '0;
      raw_word[S_INT]  = raw_int;
      raw_word[S_RST]  = raw_rst;
      raw_word[S_BUSY] = busy;
   end

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFF_LOAD_LO): bus_rdata = DATA_W'(load_val[HALF_W-1:0]);
         ADDR_W'(OFF_LOAD_HI): bus_rdata = DATA_W'(load_val[DATA_W-1:HALF_W]);
         ADDR_W'(OFF_PRE_LO):  bus_rdata = DATA_W'(pre_val[HALF_W-1:0]);
         ADDR_W'(OFF_PRE_HI):  bus_rdata = DATA_W'(pre_val[DATA_W-1:HALF_W]);
         ADDR_W'(OFF_CTRL):    bus_rdata = DATA_W'(ctrl);
         ADDR_W'(OFF_RAW):     bus_rdata = raw_word;
         ADDR_W'(OFF_MASK):    bus_rdata = DATA_W'(mask);
         ADDR_W'(OFF_CNT_LO):  bus_rdata = DATA_W'(count[HALF_W-1:0]);
         ADDR_W'(OFF_CNT_HI):  bus_rdata = DATA_W'(count[DATA_W-1:HALF_W]);
         ADDR_W'(OFF_LOCK):    bus_rdata = DATA_W'(unlocked);
         default:              bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
   import wdk_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic              unlocked,
   input logic [3:0]        ctrl,
   input logic [DATA_W-1:0] count,
   input logic              busy,
   input logic              raw_int,
   input logic              irq,
   input logic              rst_req
);
   logic load_hit;
   assign load_hit = addr == ADDR_W'(OFF_LOAD_LO) || addr == ADDR_W'(OFF_LOAD_HI) ||
                     addr == ADDR_W'(OFF_PRE_LO) || addr == ADDR_W'(OFF_PRE_HI);

   assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && !(we && addr == ADDR_W'(OFF_LOCK))) |=> $stable(ctrl));

   assert_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && unlocked && load_hit) |=> busy);

   assert_count_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> raw_int);

   assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_rst_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> count == '0);
endmodule

bind wdog_keylock wdk_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .we(bus_we), .addr(bus_addr),
   .unlocked(unlocked), .ctrl(ctrl), .count(count), .busy(busy),
   .raw_int(raw_int), .irq(irq), .rst_req(rst_req)
);

// File: tb/wdog_keylock_test.sv
`timescale 1ns/1ps
module wdog_keylock_test;
   logic        clk = 0, rst_n = 0, tick = 0, bus_we = 0;
   logic [5:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic        irq, rst_req;
   int checks = 0, errors = 0, pulses = 0;
   bit done = 0;
   logic [31:0] v;

   always #4 clk = ~clk;

   wdog_keylock uut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .rst_req(rst_req));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; #1 d = bus_rdata;
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      if (rst_req) pulses++;
   endtask

   task automatic load(input logic [31:0] t, input logic [31:0] p);
      wr(6'h00, {16'h0, t[15:0]}); wr(6'h04, {16'h0, t[31:16]});
      wr(6'h2C, {16'h0, p[15:0]}); wr(6'h30, {16'h0, p[31:16]});
   endtask

   task automatic rd_cnt(output logic [31:0] c);
      logic [31:0] lo, hi;
      rd(6'h18, lo); rd(6'h1C, hi);
      c = {hi[15:0], lo[15:0]};
   endtask

   initial begin
      #1600000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(6'h20, v); chk("R1 lock", v, 0);
      rd(6'h08, v); chk("R1 ctrl", v, 0);
      rd(6'h10, v); chk("R1 raw", v, 0);
      rd(6'h14, v); chk("R1 mask", v, 0);
      rd_cnt(v); chk("R1 count", v, 0);
      chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0);
      // R3 locked writes ignored
      wr(6'h08, 32'hB); rd(6'h08, v); chk("R3 ctrl locked", v, 0);
      wr(6'h00, 32'h7); rd(6'h00, v); chk("R3 load locked", v, 0);
      rd(6'h10, v); chk("R3 no busy", v, 0);
      // R2 key and relock
      wr(6'h20, 32'hE551); rd(6'h20, v); chk("R2 unlocked", v, 1);
      wr(6'h20, 32'h1234); rd(6'h20, v); chk("R2 relocked", v, 0);
      wr(6'h20, 32'hE551); rd(6'h20, v); chk("R2 unlocked again", v, 1);
      // sweep: R5 R6 R7
      for (int t = 3; t <= 7; t++) begin
         for (int p = 1; p < t; p++) begin
            wr(6'h08, 0); wr(6'h0C, 32'h9);
            load(t, p);
            rd(6'h10, v); chk("R5 busy set", v[4], 1);
            do_tick(); rd(6'h10, v); chk("R5 busy after one tick", v[4], 1);
            do_tick(); rd(6'h10, v); chk("R5 busy clear", v[4], 0);
            rd_cnt(v); chk("R5 loaded", v, t);
            wr(6'h08, 32'h3);
            for (int k = 1; k <= t; k++) begin
               do_tick();
               rd_cnt(v); chk("R6 count", v, t - k);
               rd(6'h10, v); chk("R7 raw int", v[0], (t - k) <= p);
            end
            do_tick(); rd_cnt(v); chk("R6 hold zero", v, 0);
         end
      end
      // R7 gating
      #1 chk("R7 irq on", irq, 1);
      wr(6'h14, 1); rd(6'h14, v); chk("R7 mask rd", v, 1);
      #1 chk("R7 irq masked", irq, 0);
      wr(6'h14, 0); #1 chk("R7 irq unmasked", irq, 1);
      wr(6'h08, 32'h2); #1 chk("R7 irq disabled", irq, 0);
      // R9 clears
      rd(6'h10, v); chk("R9 both raw set", v[3:0], 4'h9);
      wr(6'h0C, 1); rd(6'h10, v); chk("R9 int cleared", v[3:0], 4'h8);
      wr(6'h0C, 8); rd(6'h10, v); chk("R9 rst cleared", v[3:0], 4'h0);
      // R8 reset pulse
      wr(6'h08, 0); load(5, 2); do_tick(); do_tick();
      pulses = 0; wr(6'h08, 32'hB);
      repeat (8) do_tick();
      chk("R8 one pulse", pulses, 1);
      rd(6'h10, v); chk("R8 raw rst", v[3], 1);
      wr(6'h0C, 9); wr(6'h08, 0); load(4, 1); do_tick(); do_tick();
      pulses = 0; wr(6'h08, 32'h3);
      repeat (6) do_tick();
      chk("R8 no pulse without enable", pulses, 0);
      rd(6'h10, v); chk("R8 raw rst without enable", v[3], 1);
      // R4 halves
      wr(6'h08, 0); load(32'h0001_0005, 32'h0000_0001); do_tick(); do_tick();
      rd(6'h04, v); chk("R4 load hi rd", v, 1);
      rd(6'h18, v); chk("R4 count lo", v, 5);
      rd(6'h1C, v); chk("R4 count hi", v, 1);
      // R10 kick
      wr(6'h08, 32'h3); repeat (3) do_tick();
      rd_cnt(v); chk("R10 running", v, 32'h10002);
      wr(6'h00, 9); do_tick();
      rd_cnt(v); chk("R10 held while busy", v, 32'h10002);
      do_tick(); rd_cnt(v); chk("R10 restarted", v, 32'h10009);
      do_tick(); rd_cnt(v); chk("R10 counting", v, 32'h10008);
      // R3 locked stop ignored
      wr(6'h20, 0); wr(6'h08, 0);
      rd(6'h08, v); chk("R3 ctrl kept", v, 3);
      do_tick(); rd_cnt(v); chk("R3 still counting", v, 32'h10007);
      // R6 stop
      wr(6'h20, 32'hE551); wr(6'h08, 0);
      do_tick(); do_tick(); rd_cnt(v); chk("R6 stopped", v, 32'h10007);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule